// File: doc/BRIEF.md
# Paged Memory Window Decoder

This block sits between a Z80 host bus and an expansion card's ROM and RAM store. It watches memory cycles at two windows at the top of the host's address map: a lower window from E300 to EFFF and an upper window from F000 to FFFF. Each window has its own page number, so firmware can map any 4 KB slice of a store of up to 512 KB into either window. A storage-select flag sends both windows either to the ROM or to the RAM. The block drives active-low chip selects and the full store address.

On hosts that bank their own DRAM over the upper address space through I/O port writes, the block listens to those writes and turns the card windows off while the host memory covers them. On the slowest host, the floppy controller's data-request line takes the place of store address bit 10 during ROM access. A polling loop is then not needed, because the request line itself jumps between two mirrored 1 KB copies of the read routine.

The outputs are registered on the system clock, so a decode glitch while the address bus settles never reaches the memories. Page and select registers are written through host I/O ports. Reading them back is handled outside this block.

Top module: `mwin_pager`

## Requirements
- R1: An I/O write (iorq_n and wr_n low) to port 0x60 loads the lower-window page and one to port 0x61 loads the upper-window page, each taken from cpu_wdata. The registered store_addr is {page, cpu_addr[11:0]}. The upper page is used when cpu_addr[15:12] is F, and the lower page is used otherwise.
- R2: A chip select asserts only for a memory cycle (mreq_n low with rd_n or wr_n low) whose address lies in E300–EFFF or F000–FFFF. E000–E2FF and every address below E000 never assert a chip select.
- R3: Bit 0 of a write to port 0x62 selects the store: 0 routes the windows to rom_cs_n and 1 routes them to ram_cs_n. Both chip selects are never low together.
- R4: rom_cs_n, ram_cs_n and store_addr are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R5: In host modes 1 and 4, a write to port 0xE5 sets an inhibit state that keeps both chip selects high. Writes to 0xE3, 0xE4 or 0xE6 clear it.
- R6: In host modes 1 and 4, a write to port 0xE1 sets a host-overlay state that keeps both chip selects high. Writes to 0xE3 or 0xE4 clear it, and a write to 0xE6 leaves it set.
- R7: In every mode other than 1 and 4, writes to ports 0xE1 and 0xE3–0xE6 change neither the inhibit state nor the host-overlay state.
- R8: In mode 0 with ROM selected, store_addr bit 10 equals the drq input. With RAM selected, or in any other mode, bit 10 equals cpu_addr[10].
- R9: Reset sets both pages to 0, selects ROM, clears the inhibit and host-overlay states and drives both chip selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | Host address bus; the low byte is the port number in I/O cycles |
| mreq_n | input | 1 | Host memory request, active low |
| iorq_n | input | 1 | Host I/O request, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| cpu_wdata | input | PAGE_W (7) | Low host data bits, carrying page numbers and the store-select bit |
| mode | input | 3 | Host machine mode jumpers, held static |
| drq | input | 1 | Floppy controller data request |
| rom_cs_n | output | 1 | ROM chip select, active low, registered |
| ram_cs_n | output | 1 | RAM chip select, active low, registered |
| store_addr | output | PAGE_W+12 (19) | Store address: page in the upper bits, CPU offset in the lower |

## Verification
A single port write can change both host states in the same cycle. A write to 0xE3 or 0xE4 clears inhibit and host overlay together, while 0xE6 clears only the inhibit. The bench sets both states and then issues each clearing write. It follows every write with a window read, and judges from the chip selects whether the windows came back at that point or stayed blocked. The bench also lets a DRQ override and a page lookup shape the same registered address. It checks that bit 10 follows drq while bits 18:12 still carry the upper page.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  // Host I/O ports owned by the card
  localparam logic [7:0] PORT_PAGE_LO = 8'h60;
  localparam logic [7:0] PORT_PAGE_HI = 8'h61;
  localparam logic [7:0] PORT_STORE   = 8'h62;

  // Host memory-management ports that are snooped
  localparam logic [7:0] HPORT_OVERLAY  = 8'hE1;
  localparam logic [7:0] HPORT_REST_A   = 8'hE3;
  localparam logic [7:0] HPORT_REST_B   = 8'hE4;
  localparam logic [7:0] HPORT_INHIBIT  = 8'hE5;
  localparam logic [7:0] HPORT_UNINHIB  = 8'hE6;

  // Window bounds
  localparam logic [15:0] WIN_LO_FIRST = 16'hE300;
  localparam logic [15:0] WIN_LO_LAST  = 16'hEFFF;
  localparam logic [3:0]  WIN_HI_NIB   = 4'hF;

  // Host modes
  localparam logic [2:0] MODE_DRQ_MUX = 3'd0;
  localparam logic [2:0] MODE_SNOOP_A = 3'd1;
  localparam logic [2:0] MODE_SNOOP_B = 3'd4;

  typedef enum logic {STORE_ROM = 1'b0, STORE_RAM = 1'b1} store_e;
endpackage

// File: rtl/mwin_io_regs.sv
module mwin_io_regs
  import mwin_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [7:0]        port,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] page_lo,
  output logic [PAGE_W-1:0] page_hi,
  output store_e            store
);
  logic [PAGE_W-1:0] page_lo_nx, page_hi_nx;
  store_e            store_nx;
  logic              en_lo, en_hi, en_st;

  assign en_lo = io_wr && (port == PORT_PAGE_LO);
  assign en_hi = io_wr && (port == PORT_PAGE_HI);
  assign en_st = io_wr && (port == PORT_STORE);

  always_comb begin
    page_lo_nx = page_lo;
    page_hi_nx = page_hi;
    store_nx   = store;
    if (en_lo) page_lo_nx = wdata;
    if (en_hi) page_hi_nx = wdata;
    if (en_st) store_nx   = wdata[0] ? STORE_RAM : STORE_ROM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_lo <= '0;
      page_hi <= '0;
      store   <= STORE_ROM;
    end else begin
      page_lo <= page_lo_nx;
      page_hi <= page_hi_nx;
      store   <= store_nx;
    end
  end
endmodule

// File: rtl/mwin_host_snoop.sv
module mwin_host_snoop
  import mwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       snoop_en,
  input  logic [7:0] port,
  output logic       inhibit,
  output logic       overlay
);
  logic inhibit_nx, overlay_nx;

  always_comb begin
    inhibit_nx = inhibit;
    overlay_nx = overlay;
    if (io_wr && snoop_en) begin
      unique case (port)
        HPORT_INHIBIT: inhibit_nx = 1'b1;
        HPORT_UNINHIB: inhibit_nx = 1'b0;
        HPORT_OVERLAY: overlay_nx = 1'b1;
        HPORT_REST_A, HPORT_REST_B: begin
          inhibit_nx = 1'b0;
          overlay_nx = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit <= 1'b0;
      overlay <= 1'b0;
    end else begin
      inhibit <= inhibit_nx;
      overlay <= overlay_nx;
    end
  end
endmodule

// File: rtl/mwin_addr_map.sv
module mwin_addr_map
  import mwin_pkg::*;
#(
  parameter int PAGE_W  = 7,
  parameter int OFS_W   = 12,
  parameter int DRQ_BIT = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [15:0]              cpu_addr,
  input  logic                     mem_cyc,
  input  logic                     blocked,
  input  logic                     drq_mux,
  input  logic                     drq,
  input  store_e                   store,
  input  logic [PAGE_W-1:0]        page_lo,
  input  logic [PAGE_W-1:0]        page_hi,
  output logic                     rom_cs_n,
  output logic                     ram_cs_n,
  output logic [PAGE_W+OFS_W-1:0]  store_addr
);
  localparam int SA_W = PAGE_W + OFS_W;

  logic            in_hi, in_lo, hit;
  logic            rom_nx, ram_nx;
  logic [SA_W-1:0] addr_nx;

  assign in_hi = (cpu_addr[15:12] == WIN_HI_NIB);
  assign in_lo = (cpu_addr >= WIN_LO_FIRST) && (cpu_addr <= WIN_LO_LAST);
  assign hit   = mem_cyc && (in_hi || in_lo) && !blocked;

  always_comb begin
    rom_nx  = !(hit && (store == STORE_ROM));
    ram_nx  = !(hit && (store == STORE_RAM));
    addr_nx = {(in_hi ? page_hi : page_lo), cpu_addr[OFS_W-1:0]};
    if (drq_mux && (store == STORE_ROM)) addr_nx[DRQ_BIT] = drq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_cs_n   <= 1'b1;
      ram_cs_n   <= 1'b1;
      store_addr <= '0;
    end else begin
      rom_cs_n   <= rom_nx;
      ram_cs_n   <= ram_nx;
      store_addr <= addr_nx;
    end
  end
endmodule

// File: rtl/mwin_pager.sv
module mwin_pager
  import mwin_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int OFS_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [15:0]              cpu_addr,
  input  logic                     mreq_n,
  input  logic                     iorq_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [PAGE_W-1:0]        cpu_wdata,
  input  logic [2:0]               mode,
  input  logic                     drq,
  output logic                     rom_cs_n,
  output logic                     ram_cs_n,
  output logic [PAGE_W+OFS_W-1:0]  store_addr
);
  logic              rst_meta_n, rst_sync_n;
  logic              io_wr, mem_cyc, snoop_en, drq_mux;
  logic [PAGE_W-1:0] page_lo, page_hi;
  store_e            store_sel;
  logic              snp_inh, snp_ovl;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign io_wr    = !iorq_n && !wr_n;
  assign mem_cyc  = !mreq_n && (!rd_n || !wr_n);
  assign snoop_en = (mode == MODE_SNOOP_A) || (mode == MODE_SNOOP_B);
  assign drq_mux  = (mode == MODE_DRQ_MUX);

  mwin_io_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .io_wr   (io_wr),
    .port    (cpu_addr[7:0]),
    .wdata   (cpu_wdata),
    .page_lo (page_lo),
    .page_hi (page_hi),
    .store   (store_sel)
  );

  mwin_host_snoop u_snoop (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .io_wr    (io_wr),
    .snoop_en (snoop_en),
    .port     (cpu_addr[7:0]),
    .inhibit  (snp_inh),
    .overlay  (snp_ovl)
  );

  mwin_addr_map #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .DRQ_BIT(10)) u_map (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cpu_addr   (cpu_addr),
    .mem_cyc    (mem_cyc),
    .blocked    (snp_inh || snp_ovl),
    .drq_mux    (drq_mux),
    .drq        (drq),
    .store      (store_sel),
    .page_lo    (page_lo),
    .page_hi    (page_hi),
    .rom_cs_n   (rom_cs_n),
    .ram_cs_n   (ram_cs_n),
    .store_addr (store_addr)
  );
endmodule

// File: rtl/mwin_pager_chk.sv
module mwin_pager_chk #(
  parameter int SA_W = 19
) (
  input logic            clk,
  input logic            rst_n,
  input logic [15:0]     cpu_addr,
  input logic            mreq_n,
  input logic            iorq_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic [2:0]      mode,
  input logic            drq,
  input logic            rom_cs_n,
  input logic            ram_cs_n,
  input logic [SA_W-1:0] store_addr,
  input logic            store_sel,
  input logic            inhibit,
  input logic            overlay
);
  // R3
  dual_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !ram_cs_n));

  // R3
  ram_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> $past(store_sel));

  // R2
  mem_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n || !ram_cs_n) |-> $past(!mreq_n && (!rd_n || !wr_n)));

  // R2
  window_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n || !ram_cs_n) |-> ($past(cpu_addr) >= 16'hE300));

  // R5
  inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (rom_cs_n && ram_cs_n));

  // R6
  overlay_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlay |=> (rom_cs_n && ram_cs_n));

  // R7
  snoop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !wr_n && mode != 3'd1 && mode != 3'd4) |=> ($stable(inhibit) && $stable(overlay)));

  // R8
  drq_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !store_sel) |=> (store_addr[10] == $past(drq)));
endmodule

bind mwin_pager mwin_pager_chk #(.SA_W(PAGE_W + OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cpu_addr   (cpu_addr),
  .mreq_n     (mreq_n),
  .iorq_n     (iorq_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .mode       (mode),
  .drq        (drq),
  .rom_cs_n   (rom_cs_n),
  .ram_cs_n   (ram_cs_n),
  .store_addr (store_addr),
  .store_sel  (store_sel),
  .inhibit    (snp_inh),
  .overlay    (snp_ovl)
);

// File: tb/mwin_pager_test.sv
module mwin_pager_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        mreq_n, iorq_n, rd_n, wr_n;
  logic [6:0]  cpu_wdata;
  logic [2:0]  mode;
  logic        drq;
  logic        rom_cs_n, ram_cs_n;
  logic [18:0] store_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mwin_pager uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .cpu_wdata(cpu_wdata),
    .mode(mode), .drq(drq), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .store_addr(store_addr)
  );

  // {addr, mreq_n, rd_n, wr_n, exp rom_cs_n, exp ram_cs_n, exp store_addr}
  // with lower page 0x05, upper page 0x7F, ROM selected, mode 2
  localparam logic [39:0] VEC [8] = '{
    {16'hE300, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 19'h05300},
    {16'hE2FF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 19'h052FF},
    {16'hEFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 19'h05FFF},
    {16'hF000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 19'h7F000},
    {16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 19'h7FFFF},
    {16'hDFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 19'h05FFF},
    {16'hF400, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 19'h7F400},
    {16'hF000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 19'h7F000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; drq = 1'b0;
  endtask

  task automatic io_write(input logic [7:0] port, input logic [6:0] d);
    @(negedge clk);
    cpu_addr = {8'h00, port}; cpu_wdata = d; iorq_n = 1'b0; wr_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic mem_chk(input logic [15:0] a, input logic mq, input logic rd,
                         input logic wr, input logic d, input logic er,
                         input logic em, input logic [18:0] ea, input string req);
    @(negedge clk);
    cpu_addr = a; mreq_n = mq; rd_n = rd; wr_n = wr; drq = d;
    @(posedge clk);
    #1;
    check(rom_cs_n == er, {req, " rom_cs_n"}, 32'(rom_cs_n), 32'(er));
    check(ram_cs_n == em, {req, " ram_cs_n"}, 32'(ram_cs_n), 32'(em));
    check(store_addr == ea, {req, " store_addr"}, 32'(store_addr), 32'(ea));
    @(negedge clk);
    idle();
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check(rom_cs_n && ram_cs_n, "R9 selects high in reset", {30'd0, rom_cs_n, ram_cs_n}, 32'h3);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 3'd2; cpu_addr = '0; cpu_wdata = '0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    check(rom_cs_n && ram_cs_n && store_addr == 19'h0, "R9 reset outputs",
          {30'd0, rom_cs_n, ram_cs_n}, 32'h3);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9 defaults: pages 0, ROM selected
    mem_chk(16'hF000, 0, 0, 1, 0, 0, 1, 19'h00000, "R9 default page/store");
    mem_chk(16'hE300, 0, 0, 1, 0, 0, 1, 19'h00300, "R9 default lower page");

    // R1 page loads, then the vector walk (R1, R2)
    io_write(8'h60, 7'h05);
    io_write(8'h61, 7'h7F);
    for (int i = 0; i < 8; i++) begin
      mem_chk(VEC[i][39:24], VEC[i][23], VEC[i][22], VEC[i][21], 1'b0,
              VEC[i][20], VEC[i][19], VEC[i][18:0], $sformatf("R1/R2 vector %0d", i));
    end

    // R4: output holds until the capturing edge
    @(negedge clk);
    cpu_addr = 16'hF123; mreq_n = 1'b0; rd_n = 1'b0;
    #1;
    check(rom_cs_n == 1'b1, "R4 no change before edge", 32'(rom_cs_n), 32'h1);
    @(posedge clk);
    #1;
    check(rom_cs_n == 1'b0, "R4 change after edge", 32'(rom_cs_n), 32'h0);
    check(store_addr == 19'h7F123, "R4 address after edge", 32'(store_addr), 32'h7F123);
    @(negedge clk);
    idle();

    // R3 storage select
    io_write(8'h62, 7'h01);
    mem_chk(16'hF000, 0, 0, 1, 0, 1, 0, 19'h7F000, "R3 RAM routed");
    mem_chk(16'hE400, 0, 1, 0, 0, 1, 0, 19'h05400, "R3 RAM write lower");
    io_write(8'h62, 7'h02);
    mem_chk(16'hF000, 0, 0, 1, 0, 0, 1, 19'h7F000, "R3 D0=0 back to ROM");

    // R7: snoop ports ignored outside modes 1 and 4
    io_write(8'hE5, 7'h00);
    mem_chk(16'hF000, 0, 0, 1, 0, 0, 1, 19'h7F000, "R7 inhibit ignored mode 2");
    io_write(8'hE1, 7'h00);
    mem_chk(16'hF000, 0, 0, 1, 0, 0, 1, 19'h7F000, "R7 overlay ignored mode 2");
    mode = 3'd4;
    mem_chk(16'hF000, 0, 0, 1, 0, 0, 1, 19'h7F000, "R7 state untouched in mode 4");

    // R5 inhibit in mode 4 and mode 1
    io_write(8'hE5, 7'h00);
    mem_chk(16'hF000, 0, 0, 1, 0, 1, 1, 19'h7F000, "R5 inhibit mode 4");
    io_write(8'hE6, 7'h00);
    mem_chk(16'hF000, 0, 0, 1, 0, 0, 1, 19'h7F000, "R5 E6 clears inhibit");
    mode = 3'd1;
    io_write(8'hE5, 7'h00);
    mem_chk(16'hE300, 0, 0, 1, 0, 1, 1, 19'h05300, "R5 inhibit mode 1");
    io_write(8'hE3, 7'h00);
    mem_chk(16'hE300, 0, 0, 1, 0, 0, 1, 19'h05300, "R5 E3 clears inhibit");

    // R6 overlay; E6 does not clear it
    io_write(8'hE1, 7'h00);
    mem_chk(16'hF000, 0, 0, 1, 0, 1, 1, 19'h7F000, "R6 overlay blocks");
    io_write(8'hE6, 7'h00);
    mem_chk(16'hF000, 0, 0, 1, 0, 1, 1, 19'h7F000, "R6 E6 leaves overlay");
    io_write(8'hE4, 7'h00);
    mem_chk(16'hF000, 0, 0, 1, 0, 0, 1, 19'h7F000, "R6 E4 clears overlay");
    // both states set, one write clears both
    io_write(8'hE5, 7'h00);
    io_write(8'hE1, 7'h00);
    io_write(8'hE6, 7'h00);
    mem_chk(16'hF000, 0, 0, 1, 0, 1, 1, 19'h7F000, "R6 E6 clears only inhibit");
    io_write(8'hE5, 7'h00);
    io_write(8'hE3, 7'h00);
    mem_chk(16'hF000, 0, 0, 1, 0, 0, 1, 19'h7F000, "R5 R6 E3 clears both");

    // R9 reset clears snoop state and pages
    io_write(8'hE5, 7'h00);
    io_write(8'hE1, 7'h00);
    pulse_reset();
    mem_chk(16'hF000, 0, 0, 1, 0, 0, 1, 19'h00000, "R9 reset clears states");

    // R8 DRQ steering in mode 0
    mode = 3'd0;
    io_write(8'h61, 7'h7F);
    mem_chk(16'hF000, 0, 0, 1, 1, 0, 1, 19'h7F400, "R8 drq high sets bit 10");
    mem_chk(16'hF400, 0, 0, 1, 0, 0, 1, 19'h7F000, "R8 drq low clears bit 10");
    io_write(8'h62, 7'h01);
    mem_chk(16'hF000, 0, 0, 1, 1, 1, 0, 19'h7F000, "R8 no steer for RAM");
    io_write(8'h62, 7'h00);
    mode = 3'd2;
    mem_chk(16'hF000, 0, 0, 1, 1, 0, 1, 19'h7F000, "R8 no steer in mode 2");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule